// File: doc/BRIEF.md
# Scaler Coefficient Stream Loader

This block fills the coefficient memory of an image scaler through a two-register write port. One register sets the memory index and the other carries the data. A single start pulse begins a load. The block then writes the index register once, with the auto-increment flag set and the index at zero. After that it sends a run of data words, and the memory steps its own index after each one.

The filter has seven taps, and the same seven coefficients apply to each of seventeen phases. The block therefore lays 119 coefficient slots end to end. Slot `i` uses tap `i mod 7`. It packs two slots into each 32-bit data word, which gives sixty data writes. The final word has only one real slot left, so its upper half wraps back to tap 0.

A load runs only when the scaler id input selects the scaler that owns the sharpening coefficients. For any other id the block issues no writes and raises an error flag. The write port uses a valid/ready handshake, so the block holds each write until the target accepts it.

Top module: `coef_stream_loader`

## Requirements
- R1: After a start pulse with `scaler_id` equal to 1 while idle, `busy` rises on the next cycle. The first write presented has `wr_sel`=0 (index register), bit 10 (auto-increment) set and index bits 4:0 equal to 0.
- R2: A load issues exactly 60 data writes (`wr_sel`=1) after the index write. `busy` falls on the cycle after the 60th data write is accepted. A target that advances its index on every data write ends at index 60.
- R3: Data write k (k = 0..59) carries the coefficient of tap (2k mod 7) in bits 15:0 and the coefficient of tap ((2k+1) mod 7) in bits 31:16. Tap t is `coef_flat[16t+15:16t]`.
- R4: The last data write (k = 59) carries tap 6 in bits 15:0 and tap 0 in bits 31:16.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_sel` and `wr_data` stay unchanged on the next cycle, and the sequence does not advance.
- R6: A start pulse while idle with `scaler_id` other than 1 produces no write, keeps `busy` low and sets `err` on the next cycle. `err` stays set until a start with id 1 clears it.
- R7: A start pulse while `busy` is high is ignored. The running load still ends after exactly 60 data writes and does not restart.
- R8: After reset, `busy`, `err` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (sampled while idle) |
| scaler_id | input | 2 | Scaler selected for the load |
| coef_flat | input | 112 | Seven 16-bit tap coefficients, tap 0 in the low bits |
| wr_valid | output | 1 | Register write presented |
| wr_ready | input | 1 | Target accepts the presented write |
| wr_sel | output | 1 | 0 = index register, 1 = data register |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | Load in progress |
| err | output | 1 | Last start named a scaler that cannot take the coefficients |

## Verification
The hardest case is a stall that lands on the final word, where the upper half wraps to tap 0. A stall there must not let the count slip past sixty. A second hard case is a start pulse that arrives during a stalled load. To reach both, the bench drives `wr_ready` from a pseudo-random pattern and also from a long hold-off window. It fires extra start pulses partway through a load. A behavioural queue model predicts every presented write, and a memory model with an auto-incrementing index checks the final contents.

// File: rtl/coef_stream_loader.sv
module coef_stream_loader #(
  parameter int TAPS     = 7,
  parameter int PHASES   = 17,
  parameter int CW       = 16,
  parameter int ID_W     = 2,
  parameter int GOOD_ID  = 1,
  parameter int IDX_W    = 5,
  parameter int AINC_BIT = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ID_W-1:0]      scaler_id,
  input  logic [TAPS*CW-1:0]   coef_flat,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic                 wr_sel,
  output logic [2*CW-1:0]      wr_data,
  output logic                 busy,
  output logic                 err
);
  localparam int TOTAL  = TAPS * PHASES;
  localparam int NWORDS = (TOTAL + 1) / 2;
  localparam int TW     = $clog2(TAPS);
  localparam int NW_W   = $clog2(NWORDS + 1);
  localparam int DW     = 2 * CW;
  localparam logic [IDX_W-1:0] START_IDX = '0;
  localparam logic [DW-1:0]    IDX_WORD  = (DW'(1) << AINC_BIT) | DW'(START_IDX);

  typedef enum logic [1:0] {S_IDLE, S_INDEX, S_DATA} state_t;

  state_t          st;
  logic [TW-1:0]   tap;
  logic [NW_W-1:0] wcnt;
  logic [CW-1:0]   coef_arr [TAPS];

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign coef_arr[g] = coef_flat[g*CW +: CW];
  end

  logic [TW:0]   t2;
  logic [TW-1:0] tap_step, tap_hi;
  assign t2       = {1'b0, tap} + (TW+1)'(2);
  assign tap_step = (t2 >= (TW+1)'(TAPS)) ? TW'(t2 - (TW+1)'(TAPS)) : TW'(t2);
  assign tap_hi   = (tap == TW'(TAPS-1)) ? '0 : tap + TW'(1);

  assign busy     = (st != S_IDLE);
  assign wr_valid = busy;
  assign wr_sel   = (st == S_DATA);
  assign wr_data  = (st == S_DATA) ? {coef_arr[tap_hi], coef_arr[tap]} : IDX_WORD;

  wire accept = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tap  <= '0;
      wcnt <= '0;
      err  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          err <= (scaler_id != ID_W'(GOOD_ID));
          if (scaler_id == ID_W'(GOOD_ID)) st <= S_INDEX;
        end
        S_INDEX: if (accept) begin
          st   <= S_DATA;
          tap  <= '0;
          wcnt <= '0;
        end
        S_DATA: if (accept) begin
          tap  <= tap_step;
          wcnt <= wcnt + NW_W'(1);
          if (wcnt == NW_W'(NWORDS-1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coef_stream_loader_chk.sv
module coef_stream_loader_chk #(
  parameter int TAPS     = 7,
  parameter int PHASES   = 17,
  parameter int CW       = 16,
  parameter int ID_W     = 2,
  parameter int GOOD_ID  = 1,
  parameter int IDX_W    = 5,
  parameter int AINC_BIT = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [ID_W-1:0]    scaler_id,
  input logic [TAPS*CW-1:0] coef_flat,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic               wr_sel,
  input logic [2*CW-1:0]    wr_data,
  input logic               busy,
  input logic               err
);
  localparam int NWORDS = (TAPS * PHASES + 1) / 2;
  localparam int NW_W   = $clog2(NWORDS + 2);

  logic [NW_W-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!busy) cnt <= '0;
    else if (wr_valid && wr_ready && wr_sel) cnt <= cnt + NW_W'(1);
  end

  a_r1_index_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_valid && !wr_sel && wr_data[AINC_BIT] && (wr_data[IDX_W-1:0] == '0));

  a_r2_count_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cnt == NW_W'(NWORDS));

  a_r2_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= NW_W'(NWORDS));

  a_r4_last_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_sel && cnt == NW_W'(NWORDS-1)) |-> wr_data[2*CW-1:CW] == coef_flat[CW-1:0]);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_sel) && $stable(wr_data));

  a_r6_bad_id: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && scaler_id != ID_W'(GOOD_ID)) |=> !busy && err);

  a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);

  a_r8_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> busy);
endmodule

bind coef_stream_loader coef_stream_loader_chk #(
  .TAPS(TAPS), .PHASES(PHASES), .CW(CW), .ID_W(ID_W),
  .GOOD_ID(GOOD_ID), .IDX_W(IDX_W), .AINC_BIT(AINC_BIT)
) u_chk (.*);

// File: tb/sim_coef_stream_loader.sv
`timescale 1ns/1ps
module sim_coef_stream_loader;
  localparam int NT = 7, NW = 60, AINC = 10;

  logic clk = 0, rst_n = 0, start = 0, wr_ready = 1;
  logic [1:0] scaler_id = 1;
  logic [NT*16-1:0] coef_flat = '0;
  logic wr_valid, wr_sel, busy, err;
  logic [31:0] wr_data;

  always #5 clk = ~clk;

  coef_stream_loader u0 (.clk, .rst_n, .start, .scaler_id, .coef_flat,
    .wr_valid, .wr_ready, .wr_sel, .wr_data, .busy, .err);

  int tests = 0, fails = 0, cyc = 0, done = 0;
  logic [32:0] q[$];
  logic mbusy = 0, merr = 0, prev_stall = 0;
  int sent_data = 0;
  logic [31:0] mem [64];
  int midx = 0;
  logic mainc = 0;
  int rmode = 0, hold = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] tapc(input int t);
    return coef_flat[t*16 +: 16];
  endfunction

  function automatic logic [31:0] exp_word(input int k);
    return {tapc((2*k+1) % NT), tapc((2*k) % NT)};
  endfunction

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rmode == 0) wr_ready <= 1;
    else if (rmode == 1) wr_ready <= lfsr[0] | lfsr[3];
    else begin
      if (hold > 0) begin hold <= hold - 1; wr_ready <= 0; end
      else wr_ready <= 1;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      logic b;
      b = mbusy;
      if (wr_valid && wr_ready) begin
        if (!wr_sel) begin midx = int'(wr_data[4:0]); mainc = wr_data[AINC]; end
        else begin mem[midx] = wr_data; sent_data++; if (mainc) midx++; end
      end
      if (q.size() > 0 && wr_ready) begin
        void'(q.pop_front());
        if (q.size() == 0) mbusy = 0;
      end
      if (!b && start) begin
        if (scaler_id == 2'd1) begin
          q.push_back({1'b0, 32'h1 << AINC});
          for (int k = 0; k < NW; k++) q.push_back({1'b1, exp_word(k)});
          mbusy = 1; merr = 0;
        end else merr = 1;
      end
      #2;
      chk(prev_stall ? "R5 valid" : "R2 valid", {63'd0, wr_valid}, {63'd0, q.size() > 0});
      chk("R2 busy", {63'd0, busy}, {63'd0, mbusy});
      chk("R6 err", {63'd0, err}, {63'd0, merr});
      if (q.size() > 0) begin
        string tg;
        if (q[0][32] == 0) tg = "R1 index";
        else if (q.size() == 1) tg = "R4 last word";
        else if (prev_stall) tg = "R5 held word";
        else tg = "R3 word";
        chk(tg, {31'd0, wr_sel, wr_data}, {31'd0, q[0]});
      end
      prev_stall = (q.size() > 0) && !wr_ready;
    end
  end

  task automatic pulse_start(input logic [1:0] id);
    @(negedge clk); scaler_id = id; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mbusy || busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_load(input string tag);
    int s0;
    s0 = sent_data;
    pulse_start(2'd1);
    wait_idle();
    chk({tag, " R2 data write count"}, 64'(sent_data - s0), 64'(NW));
    chk({tag, " R2 final index"}, 64'(midx), 64'(NW));
    for (int k = 0; k < NW; k++) chk({tag, " R3 memory"}, 64'(mem[k]), 64'(exp_word(k)));
    chk({tag, " R4 last upper is tap0"}, 64'(mem[NW-1][31:16]), 64'(tapc(0)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) coef_flat[t*16 +: 16] = 16'h1000 + 16'(t * 16'h0111);
    repeat (3) @(negedge clk);
    chk("R8 reset busy", {63'd0, busy}, 64'd0);
    chk("R8 reset err", {63'd0, err}, 64'd0);
    chk("R8 reset valid", {63'd0, wr_valid}, 64'd0);
    rst_n = 1;
    @(negedge clk);

    rmode = 0;
    run_load("full-rate");

    begin
      int s0;
      s0 = sent_data;
      pulse_start(2'd2);
      repeat (4) @(negedge clk);
      chk("R6 err after bad id", {63'd0, err}, 64'd1);
      chk("R6 no busy", {63'd0, busy}, 64'd0);
      chk("R6 no writes", 64'(sent_data - s0), 64'd0);
      pulse_start(2'd0);
      repeat (2) @(negedge clk);
      chk("R6 err stays", {63'd0, err}, 64'd1);
    end

    for (int t = 0; t < NT; t++) coef_flat[t*16 +: 16] = 16'(16'hA5C3 ^ (t * 16'h1357));
    rmode = 1;
    run_load("random-ready");
    chk("R6 err cleared by good start", {63'd0, err}, 64'd0);

    begin
      int s0;
      s0 = sent_data;
      pulse_start(2'd1);
      repeat (10) @(negedge clk);
      pulse_start(2'd1);
      repeat (40) @(negedge clk);
      pulse_start(2'd3);
      wait_idle();
      chk("R7 count with extra starts", 64'(sent_data - s0), 64'(NW));
      chk("R7 no error from busy start", {63'd0, err}, 64'd0);
    end

    rmode = 2;
    for (int t = 0; t < NT; t++) coef_flat[t*16 +: 16] = 16'(16'h8001 + t * 16'h2222);
    hold = 25;
    run_load("long-stall");
    finish_run();
  end
endmodule